// File: doc/BRIEF.md
# Microcoded Six-Step Control Sequencer

This block is the control unit of a small accumulator processor. A step counter cycles through six timing steps, T0 to T5, and then starts again at T0. The current step and the 4-bit opcode held in the instruction register together address an internal table. The table returns the 8-bit control word that drives the datapath for that opcode at that step.

The first three steps form the fetch phase and give the same control word for every opcode. The last three steps form the execute phase, and their control words depend on the opcode. The step is also brought out as six active-low timing lines, one per step.

The control word is a combinational lookup from the registered step and the opcode input. It is valid in the same cycle as its step. The table is computed at elaboration and is never loaded from a file.

Top module: `useq_sequencer`

## Requirements
- R1: The timing steps follow the order T0, T1, T2, T3, T4, T5 and return to T0 after T5, advancing one step per clock when reset is low.
- R2: `step_n` is active low: in every cycle after reset exactly one of its six bits is 0, and bit k low means step Tk.
- R3: The step count clears to 0 when its increment would reach 6. The count is never left at 6 or 7, so the full cycle is exactly six clocks long.
- R4: Synchronous reset forces step T0 (`step_n` = 6'b111110) on the next clock edge from any step. When reset is released, T1 follows one clock later.
- R5: In T0 the control word is 8'hC0 for every opcode: bit 7 (program counter to address bus) and bit 6 (memory read) are set.
- R6: In T1 the control word is 8'h20 for every opcode: bit 5 (program counter increment) is set.
- R7: In T2 the control word is 8'h10 for every opcode: bit 4 (instruction register load) is set.
- R8: Opcode 4'b0000 (load accumulator) gives 8'h48 in T3, 8'h44 in T4 and 8'h00 in T5. Bit 3 is instruction-address out and bit 2 is accumulator load.
- R9: Opcode 4'b0001 (add) gives 8'h48 in T3, 8'h42 in T4 and 8'h00 in T5. Bit 1 is ALU result into the accumulator.
- R10: Opcode 4'b1110 (output) gives 8'h01 in T3 and 8'h00 in T4 and T5. Bit 0 is output register load.
- R11: Any other opcode gives an all-zero control word in T3, T4 and T5.
- R12: A change of `op_code` within a step shows on `ctrl_word` in that same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Opcode from the instruction register |
| step_n | output | 6 | Active-low one-hot timing lines, bit k for step Tk |
| ctrl_word | output | 8 | Control word for the current step and opcode |

## Verification
Synchronous reset and the natural wrap from T5 to T0 can act on the same clock edge. The bench asserts reset exactly in a T5 cycle, and also in a T3 cycle. It then checks that the next cycle is T0 with control word 8'hC0. After reset is released, it checks that the following cycle is T1, which shows that the wrap and the clear do not combine into a skipped or repeated step. A second overlap is tested as well: the opcode changes in the middle of an execute step while the step itself stays put. The control word must follow the new opcode within that cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CW_W = 8;
  typedef logic [CW_W-1:0] cword_t;

  // control word bit positions
  localparam int B_PC_OUT  = 7;
  localparam int B_MEM_RD  = 6;
  localparam int B_PC_INC  = 5;
  localparam int B_IR_LD   = 4;
  localparam int B_IRA_OUT = 3;
  localparam int B_ACC_LD  = 2;
  localparam int B_ALU_ACC = 1;
  localparam int B_OUT_LD  = 0;

  localparam int unsigned OPC_LOAD = 0;
  localparam int unsigned OPC_ADD  = 1;
  localparam int unsigned OPC_EMIT = 14;

  function automatic cword_t cw_lookup(int unsigned opc, int unsigned step);
    cword_t w;
    w = '0;
    case (step)
      0: begin
        w[B_PC_OUT] = 1'b1;
        w[B_MEM_RD] = 1'b1;
      end
      1: w[B_PC_INC] = 1'b1;
      2: w[B_IR_LD] = 1'b1;
      3: begin
        if (opc == OPC_LOAD || opc == OPC_ADD) begin
          w[B_IRA_OUT] = 1'b1;
          w[B_MEM_RD]  = 1'b1;
        end else if (opc == OPC_EMIT) begin
          w[B_OUT_LD] = 1'b1;
        end
      end
      4: begin
        if (opc == OPC_LOAD) begin
          w[B_MEM_RD] = 1'b1;
          w[B_ACC_LD] = 1'b1;
        end else if (opc == OPC_ADD) begin
          w[B_MEM_RD]  = 1'b1;
          w[B_ALU_ACC] = 1'b1;
        end
      end
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/useq_step_counter.sv
module useq_step_counter #(
  parameter int NUM_STEPS = 6,
  parameter int ST_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ST_W-1:0] step
);
  // clear when every bit set in NUM_STEPS is set in the incremented count
  localparam logic [ST_W-1:0] CLR_MASK = ST_W'(NUM_STEPS);

  logic [ST_W-1:0] inc;
  logic [ST_W-1:0] nxt;

  always_comb begin
    inc = step + ST_W'(1);
    if ((inc & CLR_MASK) == CLR_MASK) nxt = '0;
    else                              nxt = inc;
  end

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else     step <= nxt;
  end
endmodule

// File: rtl/useq_step_decoder.sv
module useq_step_decoder #(
  parameter int NUM_STEPS = 6,
  parameter int ST_W      = 3
) (
  input  logic [ST_W-1:0]      step,
  output logic [NUM_STEPS-1:0] step_n
);
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_line
    assign step_n[i] = (step != ST_W'(i));
  end
endmodule

// File: rtl/useq_ctrl_rom.sv
module useq_ctrl_rom
  import useq_pkg::*;
#(
  parameter int OP_W = 4,
  parameter int ST_W = 3
) (
  input  logic [OP_W-1:0] op_code,
  input  logic [ST_W-1:0] step,
  output cword_t          ctrl_word
);
  localparam int AW    = OP_W + ST_W;
  localparam int DEPTH = 1 << AW;
  localparam int SPAN  = 1 << ST_W;

  cword_t          tbl [DEPTH];
  logic [AW-1:0]   addr;

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    assign tbl[a] = cw_lookup(a / SPAN, a % SPAN);
  end

  assign addr      = {op_code, step};
  assign ctrl_word = tbl[addr];
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int OP_W      = 4,
  parameter int NUM_STEPS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OP_W-1:0]      op_code,
  output logic [NUM_STEPS-1:0] step_n,
  output logic [CW_W-1:0]      ctrl_word
);
  localparam int ST_W = $clog2(NUM_STEPS + 1);

  logic [ST_W-1:0] step;

  useq_step_counter #(.NUM_STEPS(NUM_STEPS), .ST_W(ST_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .step (step)
  );

  useq_step_decoder #(.NUM_STEPS(NUM_STEPS), .ST_W(ST_W)) u_dec (
    .step   (step),
    .step_n (step_n)
  );

  useq_ctrl_rom #(.OP_W(OP_W), .ST_W(ST_W)) u_rom (
    .op_code   (op_code),
    .step      (step),
    .ctrl_word (ctrl_word)
  );
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] op_code,
  input logic [5:0] step_n,
  input logic [7:0] ctrl_word
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~step_n) == 1);

  p_reset_r4: assert property (@(posedge clk)
    rst |=> step_n == 6'b111110);

  for (genvar i = 0; i < 5; i++) begin : g_adv
    p_advance_r1: assert property (@(posedge clk) disable iff (rst)
      !step_n[i] |=> !step_n[i+1]);
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !step_n[5] |=> !step_n[0]);

  p_fetch0_r5: assert property (@(posedge clk) disable iff (rst)
    !step_n[0] |-> ctrl_word == 8'hC0);

  p_fetch1_r6: assert property (@(posedge clk) disable iff (rst)
    !step_n[1] |-> ctrl_word == 8'h20);

  p_fetch2_r7: assert property (@(posedge clk) disable iff (rst)
    !step_n[2] |-> ctrl_word == 8'h10);

  p_other_r11: assert property (@(posedge clk) disable iff (rst)
    ((step_n[2:0] == 3'b111) && op_code != 4'h0 && op_code != 4'h1
     && op_code != 4'hE) |-> ctrl_word == 8'h00);
endmodule

bind useq_sequencer useq_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_code   (op_code),
  .step_n    (step_n),
  .ctrl_word (ctrl_word)
);

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_code = 4'h0;
  logic [5:0] step_n;
  logic [7:0] ctrl_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  useq_sequencer uut (
    .clk       (clk),
    .rst       (rst),
    .op_code   (op_code),
    .step_n    (step_n),
    .ctrl_word (ctrl_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] lines(input int k);
    return ~(6'b1 << k);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic go_to(input int k);
    for (int i = 0; i < 8; i++) begin
      if (step_n == lines(k)) return;
      tick();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick();
    tick();
    chk("R4 reset step", 32'(step_n), 32'(lines(0)));
    chk("R5 reset cw", 32'(ctrl_word), 32'hC0);
    rst = 1'b0;
    tick();
    chk("R4 after release", 32'(step_n), 32'(lines(1)));
  endtask

  task automatic t_order();
    go_to(0);
    for (int i = 0; i < 14; i++) begin
      chk("R1 order", 32'(step_n), 32'(lines(i % 6)));
      chk("R2 one low", 32'($countones(~step_n)), 32'd1);
      tick();
    end
    go_to(5);
    tick();
    chk("R3 wrap after T5", 32'(step_n), 32'(lines(0)));
  endtask

  task automatic t_fetch(input logic [3:0] op);
    op_code = op;
    go_to(0);
    chk("R5 T0 cw", 32'(ctrl_word), 32'hC0);
    tick();
    chk("R6 T1 cw", 32'(ctrl_word), 32'h20);
    tick();
    chk("R7 T2 cw", 32'(ctrl_word), 32'h10);
  endtask

  task automatic t_exec(input string req, input logic [3:0] op,
                        input logic [7:0] e3, input logic [7:0] e4, input logic [7:0] e5);
    op_code = op;
    go_to(3);
    chk(req, 32'(ctrl_word), 32'(e3));
    tick();
    chk(req, 32'(ctrl_word), 32'(e4));
    tick();
    chk(req, 32'(ctrl_word), 32'(e5));
  endtask

  task automatic t_same_cycle();
    op_code = 4'h0;
    go_to(4);
    chk("R12 before change", 32'(ctrl_word), 32'h44);
    op_code = 4'h1;
    #1;
    chk("R12 same cycle", 32'(ctrl_word), 32'h42);
    op_code = 4'hE;
    #1;
    chk("R12 same cycle other", 32'(ctrl_word), 32'h00);
    chk("R12 step held", 32'(step_n), 32'(lines(4)));
  endtask

  task automatic t_reset_collide(input int at);
    go_to(at);
    rst = 1'b1;
    tick();
    chk("R4 reset in step", 32'(step_n), 32'(lines(0)));
    chk("R5 cw after reset", 32'(ctrl_word), 32'hC0);
    rst = 1'b0;
    tick();
    chk("R4 T1 after release", 32'(step_n), 32'(lines(1)));
    tick();
    chk("R1 T2 next", 32'(step_n), 32'(lines(2)));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_order();
    t_fetch(4'h0);
    t_fetch(4'h1);
    t_fetch(4'hE);
    t_fetch(4'h7);
    t_exec("R8 load exec", 4'h0, 8'h48, 8'h44, 8'h00);
    t_exec("R9 add exec", 4'h1, 8'h48, 8'h42, 8'h00);
    t_exec("R10 out exec", 4'hE, 8'h01, 8'h00, 8'h00);
    for (int o = 2; o < 16; o++) begin
      if (o != 14) t_exec("R11 other exec", 4'(o), 8'h00, 8'h00, 8'h00);
    end
    t_same_cycle();
    t_reset_collide(5);
    t_reset_collide(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule